// File: doc/BRIEF.md
# Per-Channel DMA Interrupt Status Controller

This block gathers completion and service events from a set of DMA channels and turns them into interrupt lines. Each channel has its own transmit line and receive line. All channels share one common line. Every channel keeps sticky status bits for four sources: transmit done, receive done, transmit buffer starved and an error summary. The status bits are set by single-cycle event pulses from the channel engines. Software clears them with write-one-to-clear. A per-channel enable mask gates each source onto the lines. The transmit and receive enables are independent, so a handler can mask one direction while the other stays live.

A global routing bit picks one of two schemes. In the shared scheme, completion events also raise the normal summary and the common line. This suits a single interrupt vector. In the split scheme, completions reach only their own channel line, and the common line carries only buffer-starved and error conditions. This suits per-direction vectors.

Each channel also counts handled transmit and receive completions in saturating counters. A starved transmit buffer asks for transmit service but is not counted as a finished transfer.

Top module: `irq_status_ctl`

## Requirements
- R1: An event pulse on a source sets that channel's status bit at the next clock edge, whether or not the source is enabled. Status bit positions are: 0 transmit done, 1 receive done, 2 buffer starved, 3 error. The bit then stays set until it is cleared.
- R2: A write to the status register clears only those bits that are both written as 1 and currently enabled. An event arriving in the same cycle as the clear wins, and the bit stays set.
- R3: A channel's transmit line is high while (transmit-done status and enable) or (starved status and enable) holds. Its receive line is high while the receive-done status and its enable are both set. The two directions are masked independently. Enable bit positions match the status bit positions.
- R4: With the routing bit at 0, an enabled transmit-done or receive-done status raises the normal summary (status read bit 4) and the common line.
- R5: With the routing bit at 1, transmit-done and receive-done statuses raise neither the normal summary nor the common line. The per-channel lines still follow R3.
- R6: An enabled buffer-starved status raises the transmit line, the normal summary and the common line under either routing value.
- R7: An enabled error status raises the error summary (status read bit 5) and the common line. It does not drive the transmit or receive lines.
- R8: The transmit counter adds one in every cycle that has a transmit-done pulse while transmit-done is enabled. The receive counter does the same for receive-done pulses. A buffer-starved pulse never changes either counter.
- R9: Counters are CNT_W bits wide, hold at all-ones instead of wrapping, and are read zero-extended.
- R10: A status read is filtered by `dir_sel`. Bit 0 of `dir_sel` passes status bit 1. Bit 1 of `dir_sel` passes status bits 0 and 2. Bits 3 to 5 are always shown.
- R11: After reset, all statuses, enables, counters, the routing bit and all three lines are 0.
- R12: Register address is {channel, sub[2:0]}, with these sub values: 0 enable (read/write, bits 3:0), 1 status (read filtered, write-one-to-clear), 2 transmit counter, 3 receive counter, 4 routing bit (bit 0, one global register seen in every channel window).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tx_done | input | NUM_CH | Transmit completion pulse per channel |
| ev_rx_done | input | NUM_CH | Receive completion pulse per channel |
| ev_tx_nobuf | input | NUM_CH | Transmit buffer starved pulse per channel |
| ev_err | input | NUM_CH | Error summary pulse per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | clog2(NUM_CH)+3 | Register address {channel, sub} |
| reg_wdata | input | DATA_W | Register write data |
| dir_sel | input | 2 | Direction filter for status reads |
| reg_rdata | output | DATA_W | Combinational read data |
| tx_irq | output | NUM_CH | Per-channel transmit interrupt line |
| rx_irq | output | NUM_CH | Per-channel receive interrupt line |
| common_irq | output | 1 | Shared interrupt line |

## Verification
A status bit that is lost or left standing shows up on the channel line and on the common line in the first cycle after the event or the clear. It can be seen at the ports without any register read. A wrong routing bit shows at once on the common line during the split-scheme completion tests. A counter that counts starved events, ignores its enable or wraps only shows when the counter is read. For that reason the counters are read after each scenario, and a narrow counter width is used to reach saturation.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    SUB_EN   = 3'd0,
    SUB_ST   = 3'd1,
    SUB_TXC  = 3'd2,
    SUB_RXC  = 3'd3,
    SUB_MODE = 3'd4
  } sub_e;

  localparam int B_TI  = 0;
  localparam int B_RI  = 1;
  localparam int B_TBU = 2;
  localparam int B_ERR = 3;
  localparam int SRC_N = 4;
  localparam int VIEW_N = 6;

  // normal summary: starved always counts, completions only in shared scheme
  function automatic logic nis_calc(logic [SRC_N-1:0] st, logic [SRC_N-1:0] en,
                                    logic split_mode);
    logic [SRC_N-1:0] act;
    act = st & en;
    return act[B_TBU] | (!split_mode & (act[B_TI] | act[B_RI]));
  endfunction

  // direction filter applied to the readable status view
  function automatic logic [VIEW_N-1:0] view_filter(logic [VIEW_N-1:0] v,
                                                    logic [1:0] dir);
    logic [VIEW_N-1:0] keep;
    keep = 6'b111000;
    if (dir[0]) keep[B_RI] = 1'b1;
    if (dir[1]) begin
      keep[B_TI]  = 1'b1;
      keep[B_TBU] = 1'b1;
    end
    return v & keep;
  endfunction
endpackage

// File: rtl/irqc_satcnt.sv
module irqc_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] val
);
  function automatic logic [W-1:0] sat_next(logic [W-1:0] cur);
    return (&cur) ? cur : cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   val <= '0;
    else if (inc) val <= sat_next(val);
  end
endmodule

// File: rtl/irqc_chan.sv
module irqc_chan
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_ti,
  input  logic             ev_ri,
  input  logic             ev_tbu,
  input  logic             ev_err,
  input  logic             en_we,
  input  logic             st_clr,
  input  logic [SRC_N-1:0] wdata,
  input  logic             split_mode,
  output logic [SRC_N-1:0] en,
  output logic [SRC_N-1:0] st,
  output logic             nis,
  output logic             ais,
  output logic             tx_line,
  output logic             rx_line,
  output logic             tx_hit,
  output logic             rx_hit
);
  logic [SRC_N-1:0] set_vec;
  logic [SRC_N-1:0] clr_vec;

  assign set_vec = {ev_err, ev_tbu, ev_ri, ev_ti};
  assign clr_vec = st_clr ? (wdata & en) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0;
      st <= '0;
    end else begin
      if (en_we) en <= wdata;
      st <= (st & ~clr_vec) | set_vec;
    end
  end

  assign nis     = nis_calc(st, en, split_mode);
  assign ais     = st[B_ERR] & en[B_ERR];
  assign tx_line = (st[B_TI] & en[B_TI]) | (st[B_TBU] & en[B_TBU]);
  assign rx_line = st[B_RI] & en[B_RI];
  assign tx_hit  = ev_ti & en[B_TI];
  assign rx_hit  = ev_ri & en[B_RI];
endmodule

// File: rtl/irq_status_ctl.sv
// NUM_CH must be a power of two, at least 2
module irq_status_ctl
  import irqc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CH-1:0]            ev_tx_done,
  input  logic [NUM_CH-1:0]            ev_rx_done,
  input  logic [NUM_CH-1:0]            ev_tx_nobuf,
  input  logic [NUM_CH-1:0]            ev_err,
  input  logic                         reg_we,
  input  logic [$clog2(NUM_CH)+2:0]    reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  input  logic [1:0]                   dir_sel,
  output logic [DATA_W-1:0]            reg_rdata,
  output logic [NUM_CH-1:0]            tx_irq,
  output logic [NUM_CH-1:0]            rx_irq,
  output logic                         common_irq
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam int AW   = CH_W + 3;

  sub_e              sub;
  logic [CH_W-1:0]   ch_sel;
  logic              split_mode;
  logic              unused_wbits;

  logic [SRC_N-1:0]  en_a  [NUM_CH];
  logic [SRC_N-1:0]  st_a  [NUM_CH];
  logic [CNT_W-1:0]  txc_a [NUM_CH];
  logic [CNT_W-1:0]  rxc_a [NUM_CH];
  logic [NUM_CH-1:0] nis_v, ais_v, tx_hit_v, rx_hit_v;

  // flat views brought out for the checker
  logic [SRC_N*NUM_CH-1:0] en_flat, st_flat;
  logic [CNT_W*NUM_CH-1:0] txc_flat;

  assign sub          = sub_e'(reg_addr[2:0]);
  assign ch_sel       = reg_addr[AW-1:3];
  assign unused_wbits = ^reg_wdata[DATA_W-1:SRC_N];

  always_ff @(posedge clk) begin
    if (!rst_n)                          split_mode <= 1'b0;
    else if (reg_we && sub == SUB_MODE)  split_mode <= reg_wdata[0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = (ch_sel == CH_W'(c));

    irqc_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_ti      (ev_tx_done[c]),
      .ev_ri      (ev_rx_done[c]),
      .ev_tbu     (ev_tx_nobuf[c]),
      .ev_err     (ev_err[c]),
      .en_we      (reg_we && sel && sub == SUB_EN),
      .st_clr     (reg_we && sel && sub == SUB_ST),
      .wdata      (reg_wdata[SRC_N-1:0]),
      .split_mode (split_mode),
      .en         (en_a[c]),
      .st         (st_a[c]),
      .nis        (nis_v[c]),
      .ais        (ais_v[c]),
      .tx_line    (tx_irq[c]),
      .rx_line    (rx_irq[c]),
      .tx_hit     (tx_hit_v[c]),
      .rx_hit     (rx_hit_v[c])
    );

    irqc_satcnt #(.W(CNT_W)) u_txc (
      .clk (clk), .rst_n (rst_n), .inc (tx_hit_v[c]), .val (txc_a[c])
    );
    irqc_satcnt #(.W(CNT_W)) u_rxc (
      .clk (clk), .rst_n (rst_n), .inc (rx_hit_v[c]), .val (rxc_a[c])
    );

    assign en_flat[c*SRC_N +: SRC_N]  = en_a[c];
    assign st_flat[c*SRC_N +: SRC_N]  = st_a[c];
    assign txc_flat[c*CNT_W +: CNT_W] = txc_a[c];
  end

  assign common_irq = |(nis_v | ais_v);

  always_comb begin
    reg_rdata = '0;
    case (sub)
      SUB_EN:   reg_rdata = DATA_W'(en_a[ch_sel]);
      SUB_ST:   reg_rdata = DATA_W'(view_filter({ais_v[ch_sel], nis_v[ch_sel],
                                                 st_a[ch_sel]}, dir_sel));
      SUB_TXC:  reg_rdata = DATA_W'(txc_a[ch_sel]);
      SUB_RXC:  reg_rdata = DATA_W'(rxc_a[ch_sel]);
      SUB_MODE: reg_rdata = DATA_W'(split_mode);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_we,
  input logic                    split_mode,
  input logic [NUM_CH-1:0]       ev_tx_done,
  input logic [NUM_CH-1:0]       ev_tx_nobuf,
  input logic [NUM_CH-1:0]       ev_err,
  input logic [NUM_CH-1:0]       tx_irq,
  input logic [NUM_CH-1:0]       rx_irq,
  input logic                    common_irq,
  input logic [4*NUM_CH-1:0]     en_flat,
  input logic [4*NUM_CH-1:0]     st_flat,
  input logic [CNT_W*NUM_CH-1:0] txc_flat
);
  logic split_quiet;
  always_comb begin
    split_quiet = split_mode;
    for (int c = 0; c < NUM_CH; c++) begin
      if ((st_flat[c*4+2] & en_flat[c*4+2]) | (st_flat[c*4+3] & en_flat[c*4+3]))
        split_quiet = 1'b0;
    end
  end

  AST_SPLIT_COMMON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    split_quiet |-> !common_irq); // R5

  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    AST_TI_RAISES_TX: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_tx_done[c] && en_flat[c*4] && !reg_we) |=> tx_irq[c]); // R3

    AST_RX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq[c] |-> en_flat[c*4+1]); // R3

    AST_ERR_RAISES_COMMON: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_err[c] && en_flat[c*4+3] && !reg_we) |=> common_irq); // R7

    AST_TBU_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_tx_nobuf[c] && !ev_tx_done[c]) |=> $stable(txc_flat[c*CNT_W +: CNT_W])); // R8

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(txc_flat[c*CNT_W +: CNT_W]) <= txc_flat[c*CNT_W +: CNT_W]); // R9

    for (genvar k = 0; k < 4; k++) begin : g_b
      AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_flat[c*4+k] && !reg_we) |=> st_flat[c*4+k]); // R1
    end
  end
endmodule

bind irq_status_ctl irqc_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .split_mode  (split_mode),
  .ev_tx_done  (ev_tx_done),
  .ev_tx_nobuf (ev_tx_nobuf),
  .ev_err      (ev_err),
  .tx_irq      (tx_irq),
  .rx_irq      (rx_irq),
  .common_irq  (common_irq),
  .en_flat     (en_flat),
  .st_flat     (st_flat),
  .txc_flat    (txc_flat)
);

// File: tb/tb_irq_status_ctl.sv
module tb_irq_status_ctl;
  localparam int NCH = 4;
  localparam int CW  = 4;
  localparam logic [2:0] S_EN = 3'd0, S_ST = 3'd1, S_TXC = 3'd2, S_RXC = 3'd3, S_MODE = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] ev_tx_done = '0, ev_rx_done = '0, ev_tx_nobuf = '0, ev_err = '0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0] dir_sel = 2'b11;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] tx_irq, rx_irq;
  logic common_irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_status_ctl #(.NUM_CH(NCH), .CNT_W(CW), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
    .ev_tx_nobuf(ev_tx_nobuf), .ev_err(ev_err),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .dir_sel(dir_sel), .reg_rdata(reg_rdata),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .common_irq(common_irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int ch, logic [2:0] sub, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {ch[1:0], sub}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int ch, logic [2:0] sub, logic [1:0] dir, output logic [31:0] d);
    reg_addr = {ch[1:0], sub}; dir_sel = dir;
    #1 d = reg_rdata;
  endtask

  task automatic ev(int ch, bit ti, bit ri, bit tbu, bit er);
    @(negedge clk);
    ev_tx_done[ch] = ti; ev_rx_done[ch] = ri; ev_tx_nobuf[ch] = tbu; ev_err[ch] = er;
    @(negedge clk);
    ev_tx_done = '0; ev_rx_done = '0; ev_tx_nobuf = '0; ev_err = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R11 tx_irq", 32'(tx_irq), 0);
    chk("R11 rx_irq", 32'(rx_irq), 0);
    chk("R11 common", 32'(common_irq), 0);
    rd(2, S_ST, 2'b11, d); chk("R11 status", d, 0);
    rd(0, S_MODE, 2'b11, d); chk("R11 mode", d, 0);
    rd(3, S_TXC, 2'b11, d); chk("R11 txcnt", d, 0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    wr(1, S_EN, 0);
    ev(1, 1, 0, 0, 0);
    rd(1, S_ST, 2'b11, d); chk("R1 set while disabled", d, 32'h01);
    chk("R3 masked tx line", 32'(tx_irq), 0);
    chk("R4 masked common", 32'(common_irq), 0);
    repeat (3) @(negedge clk);
    rd(1, S_ST, 2'b11, d); chk("R1 bit holds", d, 32'h01);
    wr(1, S_EN, 1);
    rd(1, S_EN, 2'b11, d); chk("R12 enable readback", d, 32'h1);
    chk("R3 tx line on enable", 32'(tx_irq), 32'h2);
    chk("R4 common shared", 32'(common_irq), 1);
    rd(1, S_ST, 2'b11, d); chk("R4 summary bit", d, 32'h11);
    wr(1, S_ST, 32'h2);
    rd(1, S_ST, 2'b11, d); chk("R2 other bit write", d, 32'h11);
    wr(1, S_EN, 0);
    wr(1, S_ST, 32'h1);
    rd(1, S_ST, 2'b11, d); chk("R2 disabled not cleared", d, 32'h01);
    wr(1, S_EN, 1);
    wr(1, S_ST, 32'h1);
    rd(1, S_ST, 2'b11, d); chk("R2 cleared", d, 0);
    chk("R2 line drops", 32'(tx_irq), 0);
    // clear and event in the same cycle
    @(negedge clk);
    ev_tx_done[1] = 1'b1; reg_we = 1'b1; reg_addr = {2'd1, S_ST}; reg_wdata = 32'h1;
    @(negedge clk);
    ev_tx_done = '0; reg_we = 1'b0;
    rd(1, S_ST, 2'b11, d); chk("R2 event wins", d, 32'h11);
    wr(1, S_ST, 32'h1);
    rd(1, S_TXC, 2'b11, d); chk("R8 count only enabled", d, 1);
  endtask

  task automatic t_mode0();
    logic [31:0] d;
    wr(0, S_EN, 3);
    ev(0, 0, 1, 0, 0);
    chk("R4 rx line", 32'(rx_irq), 32'h1);
    chk("R4 tx quiet", 32'(tx_irq), 0);
    chk("R4 common", 32'(common_irq), 1);
    rd(0, S_ST, 2'b11, d); chk("R4 status", d, 32'h12);
    wr(0, S_ST, 32'h2);
    chk("R4 common cleared", 32'(common_irq), 0);
  endtask

  task automatic t_mode1();
    logic [31:0] d;
    wr(2, S_MODE, 1);
    rd(3, S_MODE, 2'b11, d); chk("R12 mode alias", d, 1);
    ev(0, 1, 0, 0, 0);
    chk("R5 tx line", 32'(tx_irq), 32'h1);
    chk("R5 common quiet", 32'(common_irq), 0);
    rd(0, S_ST, 2'b11, d); chk("R5 no summary", d, 32'h01);
    ev(0, 0, 1, 0, 0);
    chk("R5 rx line", 32'(rx_irq), 32'h1);
    chk("R5 common quiet rx", 32'(common_irq), 0);
    rd(0, S_ST, 2'b11, d); chk("R5 status both", d, 32'h03);
    wr(0, S_ST, 32'h3);
  endtask

  task automatic t_tbu();
    logic [31:0] d;
    wr(3, S_EN, 32'h5);
    ev(3, 0, 0, 1, 0);
    chk("R6 tx line", 32'(tx_irq), 32'h8);
    chk("R6 common in split", 32'(common_irq), 1);
    rd(3, S_ST, 2'b11, d); chk("R6 status", d, 32'h14);
    rd(3, S_TXC, 2'b11, d); chk("R8 starved not counted", d, 0);
    wr(3, S_ST, 32'h4);
    chk("R6 cleared", 32'(common_irq), 0);
    wr(0, S_MODE, 0);
  endtask

  task automatic t_err();
    logic [31:0] d;
    wr(2, S_EN, 32'h8);
    ev(2, 0, 0, 0, 1);
    chk("R7 common", 32'(common_irq), 1);
    chk("R7 no tx", 32'(tx_irq), 0);
    chk("R7 no rx", 32'(rx_irq), 0);
    rd(2, S_ST, 2'b11, d); chk("R7 status", d, 32'h28);
    wr(2, S_ST, 32'h8);
    chk("R7 cleared", 32'(common_irq), 0);
  endtask

  task automatic t_indep();
    logic [31:0] d;
    wr(2, S_EN, 32'h2);
    ev(2, 1, 1, 0, 0);
    chk("R3 rx only rx", 32'(rx_irq), 32'h4);
    chk("R3 rx only tx", 32'(tx_irq), 0);
    wr(2, S_EN, 32'h1);
    chk("R3 tx only tx", 32'(tx_irq), 32'h4);
    chk("R3 tx only rx", 32'(rx_irq), 0);
    rd(2, S_TXC, 2'b11, d); chk("R8 tx gated by enable", d, 0);
    rd(2, S_RXC, 2'b11, d); chk("R8 rx counted", d, 1);
    wr(2, S_EN, 32'h3);
    wr(2, S_ST, 32'h3);
  endtask

  task automatic t_counters();
    logic [31:0] d;
    rd(0, S_TXC, 2'b11, d); chk("R8 ch0 tx", d, 1);
    rd(0, S_RXC, 2'b11, d); chk("R8 ch0 rx", d, 2);
    @(negedge clk);
    ev_tx_done[0] = 1'b1;
    repeat (20) @(negedge clk);
    ev_tx_done[0] = 1'b0;
    rd(0, S_TXC, 2'b11, d); chk("R9 saturated", d, 32'hF);
    rd(0, S_RXC, 2'b11, d); chk("R9 rx untouched", d, 2);
    ev(0, 1, 0, 0, 0);
    rd(0, S_TXC, 2'b11, d); chk("R9 holds at max", d, 32'hF);
    wr(0, S_ST, 32'h1);
  endtask

  task automatic t_dirsel();
    logic [31:0] d;
    wr(3, S_EN, 32'h7);
    ev(3, 1, 1, 1, 0);
    rd(3, S_ST, 2'b11, d); chk("R10 both", d, 32'h17);
    rd(3, S_ST, 2'b01, d); chk("R10 rx only", d, 32'h12);
    rd(3, S_ST, 2'b10, d); chk("R10 tx only", d, 32'h15);
    rd(3, S_ST, 2'b00, d); chk("R10 none", d, 32'h10);
    wr(3, S_ST, 32'h7);
    rd(3, S_ST, 2'b11, d); chk("R10 cleared", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_mode0();
    t_mode1();
    t_tbu();
    t_err();
    t_indep();
    t_counters();
    t_dirsel();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule